// File: doc/BRIEF.md
# I/O Line Packet Deframer

This block sits between a host-side byte stream and a set of numbered I/O lines. Host data arrives as fixed-size padded packets on one byte input. The first byte of each packet names the target line and the second byte gives how many payload bytes follow. The block forwards exactly those payload bytes, each tagged with its line, and consumes the padding silently. This keeps the stream aligned for the next packet.

A second byte input carries short configuration packets that program a per-line table. Each entry holds a direction, a serial or parallel transfer mode, and a 32-bit auxiliary word: the strobe line in parallel mode, or the timer length in serial mode. Mode and auxiliary word travel with every forwarded byte, so the line drivers downstream know how to clock the data out. A packet aimed at a line that is not set up as an output is refused as a whole and flagged.

Top module: `io_pkt_deframer`

## Requirements
- R1: After reset `out_valid`, `reject` and `len_err` are low and `pkt_ready` is high. Every line starts as an input, so data sent to any line before configuration is refused.
- R2: A data packet is `PKT_BYTES` (64) bytes. Its first byte is accepted with `pkt_sop` high and carries the line number. The second byte is the payload count, and the bytes after it are payload slots. The first count slot bytes come out in order on `out_data` with `out_line`, and `out_last` is high on the final one. A count of 0 forwards nothing.
- R3: A count above 62 is treated as 62. In that case `len_err` pulses high for one cycle, in the cycle after the count byte is accepted.
- R4: Slot bytes beyond the count, and bytes that arrive outside a packet without `pkt_sop`, are consumed and never forwarded. A byte with `pkt_sop` always starts a new packet, even in the middle of the previous one.
- R5: A configuration packet is 8 bytes; its first byte is accepted with `cfg_sop` high. Byte 0 must equal `CFG_ID` (0xC5), or the whole packet is ignored. Byte 1 is the line number; a line of `NUM_LINES` or above is ignored. Byte 2 nonzero means output. Byte 3 nonzero means parallel and zero means serial. Bytes 4 to 7 form the auxiliary word, least significant byte first. The entry takes effect when byte 7 is accepted.
- R6: Each forwarded byte carries `out_parallel` and `out_aux` from the line's entry as it was when the count byte was accepted.
- R7: If the line is configured as an input, or is `NUM_LINES` or above, nothing from the packet is forwarded. `reject` then pulses high for one cycle, in the cycle after the count byte is accepted.
- R8: While `out_valid` is high and `out_ready` is low, `pkt_ready` is low and the output holds its values. Otherwise `pkt_ready` is high.
- R9: A configuration packet may complete for a line in the same cycle that a data packet's count byte for that line is accepted. The data packet is then judged by the new entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_valid | input | 1 | Data stream byte present |
| pkt_ready | output | 1 | Data stream byte accepted this cycle when valid |
| pkt_sop | input | 1 | Byte is the first of a data packet |
| pkt_byte | input | 8 | Data stream byte |
| cfg_valid | input | 1 | Configuration byte present (always accepted) |
| cfg_sop | input | 1 | Byte is the first of a configuration packet |
| cfg_byte | input | 8 | Configuration stream byte |
| out_valid | output | 1 | Payload byte available |
| out_ready | input | 1 | Downstream takes the payload byte |
| out_data | output | 8 | Payload byte |
| out_line | output | log2(NUM_LINES) | Target line of the payload byte |
| out_last | output | 1 | Final payload byte of the packet |
| out_parallel | output | 1 | Line mode: 1 parallel, 0 serial |
| out_aux | output | 32 | Strobe line (parallel) or timer length (serial) |
| reject | output | 1 | One-cycle pulse: packet refused |
| len_err | output | 1 | One-cycle pulse: count clamped |

## Verification
Two events can land on the same clock edge: a table write completing on the configuration input, and the lookup made when a data packet's count byte arrives. The bench drives both streams in lockstep so that configuration byte 7 and data byte 1 for the same line are accepted together. It does this once to open an input line and once to close an output line. It then judges the outcome only at the ports: the full tagged payload must appear with the new mode and auxiliary word, or nothing must appear and a single reject must be counted.

// File: rtl/io_deframer_pkg.sv
package io_deframer_pkg;

  localparam int CFG_BYTES = 8;
  localparam int AUX_BYTES = 4;
  localparam int AUX_W     = 8 * AUX_BYTES;

  typedef struct packed {
    logic             out_dir;
    logic             parallel;
    logic [AUX_W-1:0] aux;
  } line_cfg_t;

  function automatic logic [7:0] clamp_len(input logic [7:0] raw, input logic [7:0] cap);
    return (raw > cap) ? cap : raw;
  endfunction

  function automatic logic in_window(input logic [7:0] pos, input logic [7:0] cnt);
    return (pos >= 8'd2) && ((pos - 8'd2) < cnt);
  endfunction

  function automatic logic is_final(input logic [7:0] pos, input logic [7:0] cnt);
    return (cnt != 8'd0) && (pos == (cnt + 8'd1));
  endfunction

  function automatic logic line_ok(input logic [7:0] line, input int nlines);
    return int'(line) < nlines;
  endfunction

endpackage

// File: rtl/iodf_cfg_table.sv
module iodf_cfg_table
  import io_deframer_pkg::*;
#(
  parameter int         NUM_LINES = 16,
  parameter logic [7:0] CFG_ID    = 8'hC5
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cfg_valid,
  input  logic      cfg_sop,
  input  logic [7:0] cfg_byte,
  input  logic [7:0] rd_line,
  output line_cfg_t rd_entry,
  output logic      commit
);
  localparam int LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
  localparam int CIDX_W = $clog2(CFG_BYTES);
  localparam logic [CIDX_W-1:0] LAST_C = CIDX_W'(CFG_BYTES - 1);
  localparam int LO_W = AUX_W - 8;

  logic              c_act;
  logic [CIDX_W-1:0] cidx;
  logic [7:0]        id_q, pin_q, dir_q, par_q;
  logic [LO_W-1:0]   aux_lo;
  line_cfg_t         new_entry;
  line_cfg_t         rows_rd [NUM_LINES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_act  <= 1'b0;
      cidx   <= '0;
      id_q   <= '0;
      pin_q  <= '0;
      dir_q  <= '0;
      par_q  <= '0;
      aux_lo <= '0;
    end else if (cfg_valid) begin
      if (cfg_sop) begin
        c_act <= 1'b1;
        cidx  <= CIDX_W'(1);
        id_q  <= cfg_byte;
      end else if (c_act) begin
        case (int'(cidx))
          1:       pin_q <= cfg_byte;
          2:       dir_q <= cfg_byte;
          3:       par_q <= cfg_byte;
          default: if (cidx != LAST_C) aux_lo[8*(int'(cidx)-4) +: 8] <= cfg_byte;
        endcase
        cidx <= cidx + 1'b1;
        if (cidx == LAST_C) c_act <= 1'b0;
      end
    end
  end

  assign commit = cfg_valid && !cfg_sop && c_act && (cidx == LAST_C) &&
                  (id_q == CFG_ID) && line_ok(pin_q, NUM_LINES);

  always_comb begin
    new_entry.out_dir  = (dir_q != 8'd0);
    new_entry.parallel = (par_q != 8'd0);
    new_entry.aux      = {cfg_byte, aux_lo};
  end

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_row
    line_cfg_t row_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             row_q <= '0;
      else if (commit && int'(pin_q) == g)    row_q <= new_entry;
    end
    assign rows_rd[g] = row_q;
  end

  always_comb begin
    if (!line_ok(rd_line, NUM_LINES))            rd_entry = '0;
    else if (commit && (pin_q == rd_line))       rd_entry = new_entry;
    else                                         rd_entry = rows_rd[rd_line[LINE_W-1:0]];
  end

endmodule

// File: rtl/iodf_parser.sv
module iodf_parser
  import io_deframer_pkg::*;
#(
  parameter int PKT_BYTES = 64,
  parameter int NUM_LINES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pkt_valid,
  input  logic             pkt_sop,
  input  logic [7:0]       pkt_byte,
  input  logic             slot_free,
  output logic [7:0]       rd_line,
  input  line_cfg_t        rd_entry,
  output logic             fwd_fire,
  output logic [7:0]       fwd_data,
  output logic [7:0]       fwd_line,
  output logic             fwd_last,
  output logic             fwd_par,
  output logic [AUX_W-1:0] fwd_aux,
  output logic             hdr_event,
  output logic             reject_o,
  output logic             len_err_o
);
  localparam int IDX_W = $clog2(PKT_BYTES);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PKT_BYTES - 1);
  localparam logic [7:0] MAX_PAY = 8'(PKT_BYTES - 2);

  logic             in_pkt, keep_q, par_q;
  logic [IDX_W-1:0] idx;
  logic [7:0]       line_q, cnt_q, pos;
  logic [AUX_W-1:0] aux_q;
  logic             accept, body, hdr_ok;

  assign accept    = pkt_valid && slot_free;
  assign body      = accept && !pkt_sop && in_pkt;
  assign pos       = 8'(idx);
  assign rd_line   = line_q;
  assign hdr_event = body && (idx == IDX_W'(1));
  assign hdr_ok    = line_ok(line_q, NUM_LINES) && rd_entry.out_dir;

  assign fwd_fire = body && keep_q && in_window(pos, cnt_q);
  assign fwd_last = is_final(pos, cnt_q);
  assign fwd_data = pkt_byte;
  assign fwd_line = line_q;
  assign fwd_par  = par_q;
  assign fwd_aux  = aux_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_pkt <= 1'b0;
      idx    <= '0;
      line_q <= '0;
      cnt_q  <= '0;
      keep_q <= 1'b0;
      par_q  <= 1'b0;
      aux_q  <= '0;
    end else if (accept) begin
      if (pkt_sop) begin
        in_pkt <= 1'b1;
        idx    <= IDX_W'(1);
        line_q <= pkt_byte;
        keep_q <= 1'b0;
      end else if (in_pkt) begin
        if (idx == IDX_W'(1)) begin
          cnt_q  <= clamp_len(pkt_byte, MAX_PAY);
          keep_q <= hdr_ok;
          par_q  <= rd_entry.parallel;
          aux_q  <= rd_entry.aux;
        end
        idx <= idx + 1'b1;
        if (idx == LAST_IDX) in_pkt <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reject_o  <= 1'b0;
      len_err_o <= 1'b0;
    end else begin
      reject_o  <= hdr_event && !hdr_ok;
      len_err_o <= hdr_event && (pkt_byte > MAX_PAY);
    end
  end

endmodule

// File: rtl/iodf_out_stage.sv
module iodf_out_stage
  import io_deframer_pkg::*;
#(
  parameter int LINE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fwd_fire,
  input  logic [7:0]        fwd_data,
  input  logic [7:0]        fwd_line,
  input  logic              fwd_last,
  input  logic              fwd_par,
  input  logic [AUX_W-1:0]  fwd_aux,
  input  logic              out_ready,
  output logic              slot_free,
  output logic              out_valid,
  output logic [7:0]        out_data,
  output logic [LINE_W-1:0] out_line,
  output logic              out_last,
  output logic              out_parallel,
  output logic [AUX_W-1:0]  out_aux
);
  assign slot_free = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_data     <= '0;
      out_line     <= '0;
      out_last     <= 1'b0;
      out_parallel <= 1'b0;
      out_aux      <= '0;
    end else if (slot_free) begin
      out_valid    <= fwd_fire;
      out_data     <= fwd_data;
      out_line     <= fwd_line[LINE_W-1:0];
      out_last     <= fwd_fire && fwd_last;
      out_parallel <= fwd_par;
      out_aux      <= fwd_aux;
    end
  end

endmodule

// File: rtl/io_pkt_deframer.sv
module io_pkt_deframer
  import io_deframer_pkg::*;
#(
  parameter int         PKT_BYTES = 64,
  parameter int         NUM_LINES = 16,
  parameter logic [7:0] CFG_ID    = 8'hC5
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         pkt_valid,
  output logic                         pkt_ready,
  input  logic                         pkt_sop,
  input  logic [7:0]                   pkt_byte,
  input  logic                         cfg_valid,
  input  logic                         cfg_sop,
  input  logic [7:0]                   cfg_byte,
  output logic                         out_valid,
  input  logic                         out_ready,
  output logic [7:0]                   out_data,
  output logic [$clog2(NUM_LINES)-1:0] out_line,
  output logic                         out_last,
  output logic                         out_parallel,
  output logic [31:0]                  out_aux,
  output logic                         reject,
  output logic                         len_err
);
  localparam int LINE_W = $clog2(NUM_LINES);

  logic             slot_free, fwd_fire, fwd_last, fwd_par, hdr_event, cfg_commit;
  logic [7:0]       rd_line, fwd_data, fwd_line;
  logic [AUX_W-1:0] fwd_aux;
  line_cfg_t        rd_entry;

  assign pkt_ready = slot_free;

  iodf_cfg_table #(.NUM_LINES(NUM_LINES), .CFG_ID(CFG_ID)) u_table (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_sop(cfg_sop),
    .cfg_byte(cfg_byte), .rd_line(rd_line), .rd_entry(rd_entry), .commit(cfg_commit)
  );

  iodf_parser #(.PKT_BYTES(PKT_BYTES), .NUM_LINES(NUM_LINES)) u_parser (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_sop(pkt_sop),
    .pkt_byte(pkt_byte), .slot_free(slot_free), .rd_line(rd_line), .rd_entry(rd_entry),
    .fwd_fire(fwd_fire), .fwd_data(fwd_data), .fwd_line(fwd_line), .fwd_last(fwd_last),
    .fwd_par(fwd_par), .fwd_aux(fwd_aux), .hdr_event(hdr_event),
    .reject_o(reject), .len_err_o(len_err)
  );

  iodf_out_stage #(.LINE_W(LINE_W)) u_out (
    .clk(clk), .rst_n(rst_n), .fwd_fire(fwd_fire), .fwd_data(fwd_data),
    .fwd_line(fwd_line), .fwd_last(fwd_last), .fwd_par(fwd_par), .fwd_aux(fwd_aux),
    .out_ready(out_ready), .slot_free(slot_free), .out_valid(out_valid),
    .out_data(out_data), .out_line(out_line), .out_last(out_last),
    .out_parallel(out_parallel), .out_aux(out_aux)
  );

endmodule

// File: rtl/iodf_checker.sv
module iodf_checker #(
  parameter int PKT_BYTES = 64,
  parameter int LINE_W    = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pkt_valid,
  input logic              pkt_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [7:0]        out_data,
  input logic [LINE_W-1:0] out_line,
  input logic              out_last,
  input logic              reject,
  input logic              len_err,
  input logic              hdr_event,
  input logic              fwd_fire,
  input logic              cfg_commit
);
  localparam logic [7:0] MAX_PAY = 8'(PKT_BYTES - 2);

  logic [7:0]        beats;
  logic              burst;
  logic [LINE_W-1:0] bline;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beats <= '0;
      burst <= 1'b0;
      bline <= '0;
    end else if (hdr_event) begin
      beats <= '0;
      burst <= 1'b0;
    end else if (out_valid && out_ready) begin
      if (out_last) begin
        beats <= '0;
        burst <= 1'b0;
      end else begin
        beats <= beats + 8'd1;
        burst <= 1'b1;
        bline <= out_line;
      end
    end
  end

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_line) && $stable(out_last)));

  assert_no_take_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !(pkt_valid && pkt_ready));

  assert_reject_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> !reject);

  assert_reject_no_out_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reject |-> !fwd_fire);

  assert_len_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    len_err |=> !len_err);

  assert_max_burst_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && beats == MAX_PAY - 8'd1) |-> out_last);

  assert_burst_line_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && burst) |-> (out_line == bline));

  assert_hdr_no_fwd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(hdr_event && fwd_fire));

  assert_commit_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_commit |=> !cfg_commit);

endmodule

bind io_pkt_deframer iodf_checker #(.PKT_BYTES(PKT_BYTES), .LINE_W(LINE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_line(out_line), .out_last(out_last), .reject(reject), .len_err(len_err),
  .hdr_event(hdr_event), .fwd_fire(fwd_fire), .cfg_commit(cfg_commit)
);

// File: tb/tb_io_pkt_deframer.sv
module tb_io_pkt_deframer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pv = 1'b0, ps = 1'b0, cv = 1'b0, cs = 1'b0, ordy = 1'b1;
  logic [7:0] pb = '0, cb = '0;
  logic pkt_ready, out_valid, out_last, out_parallel, reject, len_err;
  logic [7:0] out_data;
  logic [3:0] out_line;
  logic [31:0] out_aux;

  always #2 clk = ~clk;

  io_pkt_deframer dut (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pv), .pkt_ready(pkt_ready), .pkt_sop(ps),
    .pkt_byte(pb), .cfg_valid(cv), .cfg_sop(cs), .cfg_byte(cb),
    .out_valid(out_valid), .out_ready(ordy), .out_data(out_data), .out_line(out_line),
    .out_last(out_last), .out_parallel(out_parallel), .out_aux(out_aux),
    .reject(reject), .len_err(len_err)
  );

  int tests = 0, fails = 0;
  bit done = 0;
  bit stall_en = 0, hold_low = 0, send_busy = 0;
  logic [7:0] lfsr = 8'h5A;

  // model of the line table
  bit m_dir [16];
  bit m_par [16];
  logic [31:0] m_aux [16];

  // capture of output handshakes
  int cap_n = 0, rej_n = 0, err_n = 0;
  logic [7:0]  cap_d    [128];
  logic [3:0]  cap_line [128];
  logic        cap_last [128];
  logic        cap_par  [128];
  logic [31:0] cap_aux  [128];

  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    ordy <= hold_low ? 1'b0 : (stall_en ? (lfsr[0] | lfsr[3]) : 1'b1);
  end

  always @(posedge clk) begin
    if (rst_n) begin
      if (out_valid && ordy && cap_n < 128) begin
        cap_d[cap_n] = out_data; cap_line[cap_n] = out_line; cap_last[cap_n] = out_last;
        cap_par[cap_n] = out_parallel; cap_aux[cap_n] = out_aux;
        cap_n = cap_n + 1;
      end
      if (reject)  rej_n = rej_n + 1;
      if (len_err) err_n = err_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  task automatic put(input logic [7:0] b, input bit sop);
    @(negedge clk);
    pv = 1'b1; pb = b; ps = sop;
    #1;
    while (!pkt_ready) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic send_data(input logic [7:0] line, input logic [7:0] cnt, input logic [7:0] seed);
    send_busy = 1;
    put(line, 1'b1);
    put(cnt, 1'b0);
    for (int i = 0; i < 62; i++) put(seed + 8'(i), 1'b0);
    @(negedge clk);
    pv = 1'b0; ps = 1'b0;
    send_busy = 0;
  endtask

  task automatic send_cfg(input logic [7:0] id, input logic [7:0] line, input logic [7:0] dir,
                          input logic [7:0] par, input logic [31:0] aux);
    logic [7:0] bytes [8];
    bytes = '{id, line, dir, par, aux[7:0], aux[15:8], aux[23:16], aux[31:24]};
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      cv = 1'b1; cs = (k == 0); cb = bytes[k];
    end
    @(negedge clk);
    cv = 1'b0; cs = 1'b0;
    if (id == 8'hC5 && line < 16) begin
      m_dir[line[3:0]] = (dir != 0); m_par[line[3:0]] = (par != 0); m_aux[line[3:0]] = aux;
    end
  endtask

  task automatic clear_cap();
    @(negedge clk);
    cap_n = 0; rej_n = 0; err_n = 0;
  endtask

  task automatic drain();
    stall_en = 0;
    repeat (6) @(negedge clk);
  endtask

  task automatic check_pkt(input string req, input logic [7:0] line, input logic [7:0] cnt,
                           input logic [7:0] seed);
    bit fwd;
    int n, bad_d, bad_l, bad_t, exp_rej, exp_err;
    fwd = (line < 16) && m_dir[line[3:0]];
    n = fwd ? ((cnt > 62) ? 62 : int'(cnt)) : 0;
    exp_rej = fwd ? 0 : 1;
    exp_err = (cnt > 62) ? 1 : 0;
    bad_d = 0; bad_l = 0; bad_t = 0;
    for (int i = 0; i < cap_n; i++) begin
      if (cap_d[i] != seed + 8'(i)) bad_d++;
      if (cap_last[i] != (i == n - 1)) bad_l++;
      if (cap_line[i] != line[3:0] || cap_par[i] != m_par[line[3:0]] || cap_aux[i] != m_aux[line[3:0]])
        bad_t++;
    end
    chk(cap_n == n, req, "R2 payload count", cap_n, n);
    chk(bad_d == 0, req, "R2 payload bytes wrong", bad_d, 0);
    chk(bad_l == 0, req, "R2 last flag misplaced", bad_l, 0);
    chk(bad_t == 0, req, "R6 line/mode/aux tag wrong", bad_t, 0);
    chk(rej_n == exp_rej, req, "R7 reject pulses", rej_n, exp_rej);
    chk(err_n == exp_err, req, "R3 len_err pulses", err_n, exp_err);
  endtask

  task automatic run_vec(input string req, input logic [7:0] line, input logic [7:0] cnt,
                         input logic [7:0] seed, input bit stall);
    clear_cap();
    stall_en = stall;
    send_data(line, cnt, seed);
    drain();
    check_pkt(req, line, cnt, seed);
  endtask

  // config byte 7 and data count byte accepted in the same cycle
  task automatic same_cycle(input string req, input logic [7:0] line, input logic [7:0] dir,
                            input logic [31:0] aux, input logic [7:0] cnt, input logic [7:0] seed);
    logic [7:0] bytes [8];
    bytes = '{8'hC5, line, dir, 8'd1, aux[7:0], aux[15:8], aux[23:16], aux[31:24]};
    clear_cap();
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      cv = 1'b1; cs = (k == 0); cb = bytes[k];
    end
    @(negedge clk);
    cs = 1'b0; cb = bytes[6]; pv = 1'b1; ps = 1'b1; pb = line;
    @(negedge clk);
    cb = bytes[7]; ps = 1'b0; pb = cnt;
    #1;
    chk(pkt_ready == 1'b1, req, "R9 ready during same-cycle header", int'(pkt_ready), 1);
    @(negedge clk);
    cv = 1'b0; pv = 1'b0;
    m_dir[line[3:0]] = (dir != 0); m_par[line[3:0]] = 1'b1; m_aux[line[3:0]] = aux;
    for (int i = 0; i < 62; i++) put(seed + 8'(i), 1'b0);
    @(negedge clk);
    pv = 1'b0;
    drain();
    check_pkt(req, line, cnt, seed);
  endtask

  // line, count, seed, stall
  localparam logic [24:0] VECS [0:8] = '{
    {8'd0,   8'd5,   8'h10, 1'b0},
    {8'd1,   8'd62,  8'h40, 1'b1},
    {8'd2,   8'd0,   8'h00, 1'b0},
    {8'd3,   8'd63,  8'h80, 1'b1},
    {8'd5,   8'd10,  8'h20, 1'b0},
    {8'd200, 8'd4,   8'h30, 1'b0},
    {8'd2,   8'd255, 8'h01, 1'b1},
    {8'd0,   8'd1,   8'hF0, 1'b0},
    {8'd3,   8'd30,  8'h55, 1'b1}
  };

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    for (int i = 0; i < 16; i++) begin m_dir[i] = 0; m_par[i] = 0; m_aux[i] = '0; end
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
    chk(pkt_ready == 1'b1, "R1", "pkt_ready after reset", int'(pkt_ready), 1);
    chk(reject == 1'b0 && len_err == 1'b0, "R1", "pulses after reset", int'({reject, len_err}), 0);
    rst_n = 1'b1;

    // R1: every line starts as an input
    run_vec("R1", 8'd0, 8'd4, 8'h90, 1'b0);

    // R5: program lines; a wrong id and an out-of-range line are ignored
    send_cfg(8'hC5, 8'd0, 8'd1, 8'd0, 32'h1122_3344);
    send_cfg(8'hC5, 8'd1, 8'd1, 8'd1, 32'h0000_0005);
    send_cfg(8'hC5, 8'd2, 8'd7, 8'd1, 32'hDEAD_BEEF);
    send_cfg(8'hC5, 8'd3, 8'd1, 8'd0, 32'h0000_0007);
    send_cfg(8'h12, 8'd5, 8'd1, 8'd0, 32'hFFFF_FFFF);
    send_cfg(8'hC5, 8'd20, 8'd1, 8'd1, 32'h0BAD_0BAD);

    for (int v = 0; v < 9; v++)
      run_vec("R2/R3/R5/R6/R7", VECS[v][24:17], VECS[v][16:9], VECS[v][8:1], VECS[v][0]);

    // R4: stray bytes dropped, sop restarts a packet in progress
    clear_cap();
    put(8'h33, 1'b0);
    put(8'h44, 1'b0);
    put(8'd0, 1'b1);
    put(8'd3, 1'b0);
    send_data(8'd1, 8'd2, 8'h70);
    drain();
    check_pkt("R4", 8'd1, 8'd2, 8'h70);

    // R8: output stall holds data and blocks input
    clear_cap();
    hold_low = 1;
    fork
      send_data(8'd0, 8'd4, 8'h60);
    join_none
    repeat (8) @(negedge clk);
    #1;
    chk(out_valid == 1'b1, "R8", "out_valid during stall", int'(out_valid), 1);
    chk(pkt_ready == 1'b0, "R8", "pkt_ready during stall", int'(pkt_ready), 0);
    chk(out_data == 8'h60, "R8", "held data", int'(out_data), 8'h60);
    repeat (4) @(negedge clk);
    #1;
    chk(out_valid == 1'b1 && out_data == 8'h60, "R8", "data still held", int'(out_data), 8'h60);
    hold_low = 0;
    wait (send_busy == 0);
    drain();
    check_pkt("R8", 8'd0, 8'd4, 8'h60);

    // R9: same-cycle commit opens line 6, then closes it
    same_cycle("R9", 8'd6, 8'd1, 32'hA5A5_0006, 8'd3, 8'hC0);
    same_cycle("R9", 8'd6, 8'd0, 32'h0000_0000, 8'd3, 8'hD0);

    finish_run();
  end
endmodule